// File: doc/BRIEF.md
# Store-to-Load Forwarding Lookup

This block holds a small circular queue of in-flight stores and answers byte-forwarding lookups from a load pipeline with two stages. Stores reserve an entry in program order by presenting an address and an 8-lane byte-enable mask. The address and mask become visible to lookups only after a one-cycle staging step. Store data arrives later through a separate write port that names the entry index. Entries leave the queue in order when a release pulse is given.

A load in its first stage presents its virtual address, its physical address, its byte mask and a vector with one bit per queue entry. That vector marks the entries that are older than the load. It is computed upstream, so the lookup never compares queue pointers itself. In the same cycle the block returns a fast per-lane hit mask and a fast flag that says a hit store still lacks data. One cycle later it returns the final hit mask, the forwarded doubleword, the data-missing flag with the index of the responsible store, and a flag that says the virtual-address and physical-address hit sets disagree.

Top module: `sq_fwd_lookup`

## Requirements
- R1: After reset the queue is empty, and every lookup output is zero until stores are issued.
- R2: During a stage-1 cycle with a valid load, bit b of the fast hit mask is 1 exactly when some visible entry marked older meets three conditions: its virtual address bits above bit 2 equal the load's, its mask and the load's mask share at least one lane, and both masks have lane b set. With no valid load the fast outputs are zero.
- R3: The stage-2 hit mask equals the fast hit mask of the previous cycle. All stage-2 outputs are zero in the cycle after a cycle with no valid load.
- R4: Each forwarded byte lane b (bits 8b+7..8b of the doubleword) comes from the youngest qualifying entry. Youth is the distance from the release pointer, counted forward around the queue.
- R5: The data-missing flag, fast and in stage 2, is raised when any entry that satisfies the R2 hit condition has no data written since it was issued. The stage-2 index names the youngest such entry.
- R6: The stage-2 mismatch flag is raised when the set of entries hit by virtual address differs from the set hit by physical address. Physical matching uses the physical address bits above bit 2 under the same age, visibility and overlap conditions.
- R7: A store issued at clock edge k is invisible to lookups evaluated before edge k+1 and visible from then on.
- R8: Entries whose bit in the older vector is 0 never contribute to any lookup output.
- R9: A release pulse frees the oldest held entry, and that entry no longer produces hits.
- R10: An issue made while all 8 entries are held is ignored and leaves no entry behind.
- R11: A data write stores the doubleword for the named entry and marks it present. Lanes without a hit read as zero in the stage-2 data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_issue_valid | input | 1 | Reserve the next entry for a store |
| st_issue_vaddr | input | VA_W | Store virtual address |
| st_issue_paddr | input | PA_W | Store physical address |
| st_issue_mask | input | LANES | Store byte-lane enables |
| st_data_valid | input | 1 | Write store data |
| st_data_idx | input | IDX_W | Entry receiving the data |
| st_data_value | input | DATA_W | Lane-aligned store doubleword |
| st_release | input | 1 | Free the oldest entry |
| ld_s1_valid | input | 1 | Load lookup present in stage 1 |
| ld_s1_vaddr | input | VA_W | Load virtual address |
| ld_s1_paddr | input | PA_W | Load physical address |
| ld_s1_mask | input | LANES | Load byte-lane mask |
| ld_s1_older | input | SQ_ENTRIES | One bit per entry older than the load |
| ld_s1_fwd_mask_fast | output | LANES | Fast per-lane hit mask |
| ld_s1_data_inv_fast | output | 1 | Fast flag: a hit store lacks data |
| ld_s2_fwd_mask | output | LANES | Final per-lane hit mask |
| ld_s2_fwd_data | output | DATA_W | Forwarded doubleword |
| ld_s2_data_inv | output | 1 | A hit store lacks data |
| ld_s2_data_inv_idx | output | IDX_W | Youngest hit store lacking data |
| ld_s2_match_inv | output | 1 | Virtual and physical hit sets differ |

## Verification
The bound checker watches, on every cycle, that the fast mask stays inside the load mask and is zero when no load is present. It also watches that the stage-2 mask and data-missing flag repeat the previous fast results, that the reported missing-data entry was marked older, that lanes without a hit carry zero data, and that a mismatch follows a real load. Youngest-store selection, the two-edge visibility of a new store, in-order release, the ignored issue into a full queue and the exact forwarded bytes depend on the history of the queue. Only the bench's scenarios can show these, by comparing them with its own queue model.

// File: rtl/sqf_pkg.sv
package sqf_pkg;
    parameter int SQ_ENTRIES = 8;
    parameter int IDX_W      = $clog2(SQ_ENTRIES);
    parameter int PTR_W      = IDX_W + 1;
    parameter int LANES      = 8;
    parameter int OFF_W      = $clog2(LANES);
    parameter int DATA_W     = LANES * 8;
    parameter int VA_W       = 39;
    parameter int PA_W       = 36;

    typedef logic [LANES-1:0]      lane_mask_t;
    typedef logic [IDX_W-1:0]      sq_idx_t;
    typedef logic [VA_W-1:OFF_W]   vtag_t;
    typedef logic [PA_W-1:OFF_W]   ptag_t;

    typedef struct packed {
        vtag_t      vtag;
        ptag_t      ptag;
        lane_mask_t mask;
    } st_addr_t;

    typedef struct packed {
        logic                  valid;
        vtag_t                 vtag;
        ptag_t                 ptag;
        lane_mask_t            mask;
        logic [SQ_ENTRIES-1:0] older;
    } ld_query_t;

    typedef struct packed {
        lane_mask_t        fwd;
        logic [DATA_W-1:0] data;
        logic              dinv;
        sq_idx_t           dinv_idx;
        logic              minv;
    } ld_resp_t;

    // distance of an entry from the release pointer, wrapping around the ring
    function automatic sq_idx_t age_of(sq_idx_t idx, sq_idx_t head);
        return sq_idx_t'(idx - head);
    endfunction
endpackage

// File: rtl/sqf_store_array.sv
module sqf_store_array
    import sqf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              issue_valid,
    input  st_addr_t          issue_addr,
    input  logic              data_valid,
    input  sq_idx_t           data_idx,
    input  logic [DATA_W-1:0] data_value,
    input  logic              release_req,
    output logic              ent_valid  [SQ_ENTRIES],
    output logic              ent_dvalid [SQ_ENTRIES],
    output st_addr_t          ent_addr   [SQ_ENTRIES],
    output logic [DATA_W-1:0] ent_data   [SQ_ENTRIES],
    output sq_idx_t           head
);
    logic [PTR_W-1:0] alloc_ptr, rel_ptr;
    logic             full, empty, take, drop;
    logic             pend_valid;
    sq_idx_t          pend_idx;
    st_addr_t         pend_addr;

    assign full  = (alloc_ptr[IDX_W-1:0] == rel_ptr[IDX_W-1:0]) &&
                   (alloc_ptr[IDX_W] != rel_ptr[IDX_W]);
    assign empty = (alloc_ptr == rel_ptr);
    assign take  = issue_valid & ~full;
    assign drop  = release_req & ~empty;
    assign head  = rel_ptr[IDX_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            alloc_ptr  <= '0;
            rel_ptr    <= '0;
            pend_valid <= 1'b0;
            pend_idx   <= '0;
            pend_addr  <= '0;
            for (int i = 0; i < SQ_ENTRIES; i++) begin
                ent_valid[i]  <= 1'b0;
                ent_dvalid[i] <= 1'b0;
                ent_addr[i]   <= '0;
                ent_data[i]   <= '0;
            end
        end else begin
            // second half of the address write: the staged entry becomes visible
            if (pend_valid) begin
                ent_valid[pend_idx] <= 1'b1;
                ent_addr[pend_idx]  <= pend_addr;
            end
            if (data_valid) begin
                ent_dvalid[data_idx] <= 1'b1;
                ent_data[data_idx]   <= data_value;
            end
            pend_valid <= take;
            if (take) begin
                pend_idx                          <= alloc_ptr[IDX_W-1:0];
                pend_addr                         <= issue_addr;
                ent_dvalid[alloc_ptr[IDX_W-1:0]]  <= 1'b0;
                alloc_ptr                         <= alloc_ptr + 1'b1;
            end
            if (drop) begin
                ent_valid[rel_ptr[IDX_W-1:0]] <= 1'b0;
                rel_ptr                       <= rel_ptr + 1'b1;
            end
        end
    end
endmodule

// File: rtl/sqf_match.sv
module sqf_match
    import sqf_pkg::*;
(
    input  ld_query_t             q,
    input  logic                  ent_valid [SQ_ENTRIES],
    input  st_addr_t              ent_addr  [SQ_ENTRIES],
    output logic [SQ_ENTRIES-1:0] vhit,
    output logic [SQ_ENTRIES-1:0] phit
);
    for (genvar i = 0; i < SQ_ENTRIES; i++) begin : g_ent
        logic overlap, live;
        assign overlap = |(ent_addr[i].mask & q.mask);
        assign live    = q.valid & q.older[i] & ent_valid[i] & overlap;
        assign vhit[i] = live & (ent_addr[i].vtag == q.vtag);
        assign phit[i] = live & (ent_addr[i].ptag == q.ptag);
    end
endmodule

// File: rtl/sqf_select.sv
module sqf_select
    import sqf_pkg::*;
(
    input  lane_mask_t            ld_mask,
    input  logic [SQ_ENTRIES-1:0] vhit,
    input  lane_mask_t            ent_mask   [SQ_ENTRIES],
    input  logic                  ent_dvalid [SQ_ENTRIES],
    input  logic [DATA_W-1:0]     ent_data   [SQ_ENTRIES],
    input  sq_idx_t               head,
    output lane_mask_t            fwd,
    output logic [DATA_W-1:0]     data,
    output logic                  dinv,
    output sq_idx_t               dinv_idx
);
    // per lane: youngest hitting entry supplies the byte
    for (genvar b = 0; b < LANES; b++) begin : g_lane
        logic    hit;
        sq_idx_t pick, pick_age;
        always_comb begin
            hit      = 1'b0;
            pick     = '0;
            pick_age = '0;
            for (int i = 0; i < SQ_ENTRIES; i++) begin
                if (vhit[i] && ent_mask[i][b] && ld_mask[b] &&
                    (!hit || age_of(sq_idx_t'(i), head) > pick_age)) begin
                    hit      = 1'b1;
                    pick     = sq_idx_t'(i);
                    pick_age = age_of(sq_idx_t'(i), head);
                end
            end
        end
        assign fwd[b]         = hit;
        assign data[8*b +: 8] = hit ? ent_data[pick][8*b +: 8] : 8'h00;
    end

    // youngest hitting entry whose data is still missing
    sq_idx_t miss_age;
    always_comb begin
        dinv     = 1'b0;
        dinv_idx = '0;
        miss_age = '0;
        for (int i = 0; i < SQ_ENTRIES; i++) begin
            if (vhit[i] && !ent_dvalid[i] &&
                (!dinv || age_of(sq_idx_t'(i), head) > miss_age)) begin
                dinv     = 1'b1;
                dinv_idx = sq_idx_t'(i);
                miss_age = age_of(sq_idx_t'(i), head);
            end
        end
    end
endmodule

// File: rtl/sq_fwd_lookup.sv
module sq_fwd_lookup
    import sqf_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  st_issue_valid,
    input  logic [VA_W-1:0]       st_issue_vaddr,
    input  logic [PA_W-1:0]       st_issue_paddr,
    input  logic [LANES-1:0]      st_issue_mask,
    input  logic                  st_data_valid,
    input  logic [IDX_W-1:0]      st_data_idx,
    input  logic [DATA_W-1:0]     st_data_value,
    input  logic                  st_release,
    input  logic                  ld_s1_valid,
    input  logic [VA_W-1:0]       ld_s1_vaddr,
    input  logic [PA_W-1:0]       ld_s1_paddr,
    input  logic [LANES-1:0]      ld_s1_mask,
    input  logic [SQ_ENTRIES-1:0] ld_s1_older,
    output logic [LANES-1:0]      ld_s1_fwd_mask_fast,
    output logic                  ld_s1_data_inv_fast,
    output logic [LANES-1:0]      ld_s2_fwd_mask,
    output logic [DATA_W-1:0]     ld_s2_fwd_data,
    output logic                  ld_s2_data_inv,
    output logic [IDX_W-1:0]      ld_s2_data_inv_idx,
    output logic                  ld_s2_match_inv
);
    st_addr_t              issue_addr;
    ld_query_t             q;
    ld_resp_t              s1_resp, s2_resp;
    logic                  ent_valid  [SQ_ENTRIES];
    logic                  ent_dvalid [SQ_ENTRIES];
    st_addr_t              ent_addr   [SQ_ENTRIES];
    lane_mask_t            ent_mask   [SQ_ENTRIES];
    logic [DATA_W-1:0]     ent_data   [SQ_ENTRIES];
    sq_idx_t               head;
    logic [SQ_ENTRIES-1:0] vhit, phit;
    logic                  unused_low_bits;

    assign unused_low_bits = ^{st_issue_vaddr[OFF_W-1:0], st_issue_paddr[OFF_W-1:0],
                               ld_s1_vaddr[OFF_W-1:0], ld_s1_paddr[OFF_W-1:0]};

    assign issue_addr = '{vtag: st_issue_vaddr[VA_W-1:OFF_W],
                          ptag: st_issue_paddr[PA_W-1:OFF_W],
                          mask: st_issue_mask};
    assign q = '{valid: ld_s1_valid,
                 vtag:  ld_s1_vaddr[VA_W-1:OFF_W],
                 ptag:  ld_s1_paddr[PA_W-1:OFF_W],
                 mask:  ld_s1_mask,
                 older: ld_s1_older};

    for (genvar i = 0; i < SQ_ENTRIES; i++) begin : g_mask
        assign ent_mask[i] = ent_addr[i].mask;
    end

    sqf_store_array u_array (
        .clk, .rst,
        .issue_valid (st_issue_valid),
        .issue_addr  (issue_addr),
        .data_valid  (st_data_valid),
        .data_idx    (st_data_idx),
        .data_value  (st_data_value),
        .release_req (st_release),
        .ent_valid, .ent_dvalid, .ent_addr, .ent_data, .head
    );

    sqf_match u_match (.q, .ent_valid, .ent_addr, .vhit, .phit);

    sqf_select u_select (
        .ld_mask (q.mask), .vhit, .ent_mask, .ent_dvalid, .ent_data, .head,
        .fwd      (s1_resp.fwd),
        .data     (s1_resp.data),
        .dinv     (s1_resp.dinv),
        .dinv_idx (s1_resp.dinv_idx)
    );
    assign s1_resp.minv = (vhit != phit);

    assign ld_s1_fwd_mask_fast = s1_resp.fwd;
    assign ld_s1_data_inv_fast = s1_resp.dinv;

    always_ff @(posedge clk) begin
        if (rst)              s2_resp <= '0;
        else if (ld_s1_valid) s2_resp <= s1_resp;
        else                  s2_resp <= '0;
    end

    assign ld_s2_fwd_mask     = s2_resp.fwd;
    assign ld_s2_fwd_data     = s2_resp.data;
    assign ld_s2_data_inv     = s2_resp.dinv;
    assign ld_s2_data_inv_idx = s2_resp.dinv_idx;
    assign ld_s2_match_inv    = s2_resp.minv;
endmodule

// File: rtl/sqf_checker.sv
module sqf_checker
    import sqf_pkg::*;
(
    input logic                  clk,
    input logic                  rst,
    input logic                  ld_s1_valid,
    input logic [LANES-1:0]      ld_s1_mask,
    input logic [SQ_ENTRIES-1:0] ld_s1_older,
    input logic [LANES-1:0]      ld_s1_fwd_mask_fast,
    input logic                  ld_s1_data_inv_fast,
    input logic [LANES-1:0]      ld_s2_fwd_mask,
    input logic [DATA_W-1:0]     ld_s2_fwd_data,
    input logic                  ld_s2_data_inv,
    input logic [IDX_W-1:0]      ld_s2_data_inv_idx,
    input logic                  ld_s2_match_inv
);
    logic                  armed;
    logic [SQ_ENTRIES-1:0] older_q;
    logic                  valid_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed   <= 1'b0;
            older_q <= '0;
            valid_q <= 1'b0;
        end else begin
            armed   <= 1'b1;
            older_q <= ld_s1_older;
            valid_q <= ld_s1_valid;
        end
    end

    assert_fast_in_mask_R2: assert property (@(posedge clk) disable iff (rst)
        (ld_s1_fwd_mask_fast & ~ld_s1_mask) == '0);

    assert_idle_fast_zero_R2: assert property (@(posedge clk) disable iff (rst)
        !ld_s1_valid |-> (ld_s1_fwd_mask_fast == '0 && !ld_s1_data_inv_fast));

    assert_s2_mask_follows_R3: assert property (@(posedge clk) disable iff (rst)
        armed |-> ld_s2_fwd_mask == $past(ld_s1_fwd_mask_fast));

    assert_s2_dinv_follows_R5: assert property (@(posedge clk) disable iff (rst)
        armed |-> ld_s2_data_inv == $past(ld_s1_data_inv_fast));

    assert_dinv_idx_older_R8: assert property (@(posedge clk) disable iff (rst)
        (armed && ld_s2_data_inv) |-> older_q[ld_s2_data_inv_idx]);

    assert_minv_needs_load_R6: assert property (@(posedge clk) disable iff (rst)
        ld_s2_match_inv |-> (armed && valid_q));

    for (genvar b = 0; b < LANES; b++) begin : g_zero
        assert_unhit_lane_zero_R11: assert property (@(posedge clk) disable iff (rst)
            !ld_s2_fwd_mask[b] |-> ld_s2_fwd_data[8*b +: 8] == 8'h00);
    end
endmodule

bind sq_fwd_lookup sqf_checker i_sqf_checker (
    .clk                 (clk),
    .rst                 (rst),
    .ld_s1_valid         (ld_s1_valid),
    .ld_s1_mask          (ld_s1_mask),
    .ld_s1_older         (ld_s1_older),
    .ld_s1_fwd_mask_fast (ld_s1_fwd_mask_fast),
    .ld_s1_data_inv_fast (ld_s1_data_inv_fast),
    .ld_s2_fwd_mask      (ld_s2_fwd_mask),
    .ld_s2_fwd_data      (ld_s2_fwd_data),
    .ld_s2_data_inv      (ld_s2_data_inv),
    .ld_s2_data_inv_idx  (ld_s2_data_inv_idx),
    .ld_s2_match_inv     (ld_s2_match_inv)
);

// File: tb/test_sq_fwd_lookup.sv
module test_sq_fwd_lookup;
    import sqf_pkg::*;
    localparam int CLK_PERIOD = 10;

    logic                  clk = 1'b0;
    logic                  rst;
    logic                  st_issue_valid;
    logic [VA_W-1:0]       st_issue_vaddr;
    logic [PA_W-1:0]       st_issue_paddr;
    logic [LANES-1:0]      st_issue_mask;
    logic                  st_data_valid;
    logic [IDX_W-1:0]      st_data_idx;
    logic [DATA_W-1:0]     st_data_value;
    logic                  st_release;
    logic                  ld_s1_valid;
    logic [VA_W-1:0]       ld_s1_vaddr;
    logic [PA_W-1:0]       ld_s1_paddr;
    logic [LANES-1:0]      ld_s1_mask;
    logic [SQ_ENTRIES-1:0] ld_s1_older;
    logic [LANES-1:0]      ld_s1_fwd_mask_fast;
    logic                  ld_s1_data_inv_fast;
    logic [LANES-1:0]      ld_s2_fwd_mask;
    logic [DATA_W-1:0]     ld_s2_fwd_data;
    logic                  ld_s2_data_inv;
    logic [IDX_W-1:0]      ld_s2_data_inv_idx;
    logic                  ld_s2_match_inv;

    always #(CLK_PERIOD/2) clk = ~clk;

    sq_fwd_lookup i_sq_fwd_lookup (.*);

    int n_chk = 0;
    int n_fail = 0;

    // bench queue model
    logic              mv  [SQ_ENTRIES];
    logic              mdv [SQ_ENTRIES];
    logic [VA_W-1:0]   mva [SQ_ENTRIES];
    logic [PA_W-1:0]   mpa [SQ_ENTRIES];
    logic [LANES-1:0]  mm  [SQ_ENTRIES];
    logic [DATA_W-1:0] md  [SQ_ENTRIES];
    int                aptr, rptr;
    logic              pv;
    int                pidx;
    logic [VA_W-1:0]   pva;
    logic [PA_W-1:0]   ppa;
    logic [LANES-1:0]  pmask;

    // expected results
    logic [LANES-1:0]  x_mask;
    logic [DATA_W-1:0] x_data;
    logic              x_dinv, x_minv;
    int                x_idx;

    task automatic check(input logic ok, input string req, input logic [DATA_W-1:0] act,
                         input logic [DATA_W-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [VA_W-1:0] va_of(int tag);
        return VA_W'(tag) << OFF_W;
    endfunction
    function automatic logic [PA_W-1:0] pa_of(int tag);
        return PA_W'(tag) << OFF_W;
    endfunction

    task automatic set_idle();
        st_issue_valid = 0; st_issue_vaddr = '0; st_issue_paddr = '0; st_issue_mask = '0;
        st_data_valid = 0; st_data_idx = '0; st_data_value = '0; st_release = 0;
        ld_s1_valid = 0; ld_s1_vaddr = '0; ld_s1_paddr = '0; ld_s1_mask = '0; ld_s1_older = '0;
    endtask

    task automatic compute_exp();
        int best_age [LANES];
        int best_idx [LANES];
        int dage;
        x_mask = '0; x_data = '0; x_dinv = 0; x_minv = 0; x_idx = 0; dage = -1;
        for (int b = 0; b < LANES; b++) begin best_age[b] = -1; best_idx[b] = 0; end
        for (int i = 0; i < SQ_ENTRIES; i++) begin
            logic live, vh, ph;
            int   age;
            age  = (i - (rptr % SQ_ENTRIES) + SQ_ENTRIES) % SQ_ENTRIES;
            live = ld_s1_valid && ld_s1_older[i] && mv[i] && ((mm[i] & ld_s1_mask) != 0);
            vh   = live && (mva[i][VA_W-1:OFF_W] == ld_s1_vaddr[VA_W-1:OFF_W]);
            ph   = live && (mpa[i][PA_W-1:OFF_W] == ld_s1_paddr[PA_W-1:OFF_W]);
            if (vh != ph) x_minv = 1;
            if (vh && !mdv[i] && age > dage) begin dage = age; x_dinv = 1; x_idx = i; end
            for (int b = 0; b < LANES; b++)
                if (vh && mm[i][b] && ld_s1_mask[b] && age > best_age[b]) begin
                    best_age[b] = age; best_idx[b] = i;
                end
        end
        for (int b = 0; b < LANES; b++)
            if (best_age[b] >= 0) begin
                x_mask[b] = 1;
                x_data[8*b +: 8] = md[best_idx[b]][8*b +: 8];
            end
    endtask

    task automatic model_edge();
        logic take, drop;
        int   cnt;
        cnt  = aptr - rptr;
        take = st_issue_valid && cnt < SQ_ENTRIES;
        drop = st_release && cnt > 0;
        if (pv) begin mv[pidx] = 1; mva[pidx] = pva; mpa[pidx] = ppa; mm[pidx] = pmask; end
        if (st_data_valid) begin mdv[st_data_idx] = 1; md[st_data_idx] = st_data_value; end
        pv = take;
        if (take) begin
            pidx = aptr % SQ_ENTRIES; pva = st_issue_vaddr; ppa = st_issue_paddr;
            pmask = st_issue_mask; mdv[pidx] = 0; aptr++;
        end
        if (drop) begin mv[rptr % SQ_ENTRIES] = 0; rptr++; end
    endtask

    // one clock: check stage 1 now, stage 2 after the edge, then clear inputs
    task automatic tick();
        logic [LANES-1:0]  s_mask;
        logic [DATA_W-1:0] s_data;
        logic              s_dinv, s_minv;
        int                s_idx;
        #1;
        compute_exp();
        check(ld_s1_fwd_mask_fast == x_mask, "R2 fast mask", DATA_W'(ld_s1_fwd_mask_fast), DATA_W'(x_mask));
        check(ld_s1_data_inv_fast == x_dinv, "R5 fast data-missing", DATA_W'(ld_s1_data_inv_fast), DATA_W'(x_dinv));
        s_mask = x_mask; s_data = x_data; s_dinv = x_dinv; s_minv = x_minv; s_idx = x_idx;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check(ld_s2_fwd_mask == s_mask, "R3 stage-2 mask", DATA_W'(ld_s2_fwd_mask), DATA_W'(s_mask));
        check(ld_s2_fwd_data == s_data, "R4 stage-2 data", ld_s2_fwd_data, s_data);
        check(ld_s2_data_inv == s_dinv && (!s_dinv || int'(ld_s2_data_inv_idx) == s_idx),
              "R5 stage-2 data-missing/index",
              DATA_W'({ld_s2_data_inv, ld_s2_data_inv_idx}), DATA_W'({s_dinv, IDX_W'(s_idx)}));
        check(ld_s2_match_inv == s_minv, "R6 mismatch", DATA_W'(ld_s2_match_inv), DATA_W'(s_minv));
        set_idle();
    endtask

    task automatic issue(input int vt, input int pt, input logic [LANES-1:0] m);
        st_issue_valid = 1; st_issue_vaddr = va_of(vt); st_issue_paddr = pa_of(pt); st_issue_mask = m;
    endtask

    task automatic query(input int vt, input int pt, input logic [LANES-1:0] m,
                         input logic [SQ_ENTRIES-1:0] old);
        ld_s1_valid = 1; ld_s1_vaddr = va_of(vt) | VA_W'($urandom_range(7));
        ld_s1_paddr = pa_of(pt) | PA_W'($urandom_range(7)); ld_s1_mask = m; ld_s1_older = old;
    endtask

    task automatic data_wr(input int idx, input logic [DATA_W-1:0] v);
        st_data_valid = 1; st_data_idx = IDX_W'(idx); st_data_value = v;
    endtask

    localparam int TA = 5;
    localparam int TB = 12;
    localparam int POFF = 64;

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < SQ_ENTRIES; i++) begin
            mv[i] = 0; mdv[i] = 0; mva[i] = '0; mpa[i] = '0; mm[i] = '0; md[i] = '0;
        end
        aptr = 0; rptr = 0; pv = 0; pidx = 0; pva = '0; ppa = '0; pmask = '0;
        set_idle();
        rst = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1: reset state
        check({ld_s1_fwd_mask_fast, ld_s1_data_inv_fast, ld_s2_fwd_mask, ld_s2_data_inv,
               ld_s2_match_inv} == '0 && ld_s2_fwd_data == '0, "R1 reset outputs",
              ld_s2_fwd_data, '0);
        query(TA, TA + POFF, 8'hFF, 8'hFF);
        #1 check(ld_s1_fwd_mask_fast == '0, "R1 empty queue", DATA_W'(ld_s1_fwd_mask_fast), '0);
        tick();

        // R7: staged visibility
        issue(TA, TA + POFF, 8'h0F); tick();
        query(TA, TA + POFF, 8'hFF, 8'h01);
        #1 check(ld_s1_fwd_mask_fast == 8'h00, "R7 not yet visible", DATA_W'(ld_s1_fwd_mask_fast), '0);
        tick();
        query(TA, TA + POFF, 8'hFF, 8'h01);
        #1 check(ld_s1_fwd_mask_fast == 8'h0F, "R7 visible", DATA_W'(ld_s1_fwd_mask_fast), 64'h0F);
        check(ld_s1_data_inv_fast == 1'b1, "R5 fast flag without data", DATA_W'(ld_s1_data_inv_fast), 64'h1);
        tick();
        check(ld_s2_data_inv && ld_s2_data_inv_idx == 0, "R5 index of missing store",
              DATA_W'(ld_s2_data_inv_idx), 64'h0);

        // R11, R4, R8: data and youngest selection
        data_wr(0, 64'h1111_2222_3333_4444); tick();
        issue(TA, TA + POFF, 8'h03); tick();
        data_wr(1, 64'hAAAA_BBBB_CCCC_DDDD); tick();
        query(TA, TA + POFF, 8'hFF, 8'h03); tick();
        check(ld_s2_fwd_data == 64'h0000_0000_3333_DDDD, "R4 youngest per lane",
              ld_s2_fwd_data, 64'h0000_0000_3333_DDDD);
        check(ld_s2_fwd_mask == 8'h0F && !ld_s2_data_inv, "R11 data present",
              DATA_W'(ld_s2_fwd_mask), 64'h0F);
        query(TA, TA + POFF, 8'hFF, 8'h01); tick();
        check(ld_s2_fwd_data == 64'h0000_0000_3333_4444, "R8 younger store not older",
              ld_s2_fwd_data, 64'h0000_0000_3333_4444);
        tick();
        check(ld_s2_fwd_mask == 8'h00 && ld_s2_fwd_data == '0, "R3 idle stage 2",
              ld_s2_fwd_data, '0);

        // R6: address disagreement, R5: youngest missing
        issue(TA, TA + POFF + 1, 8'hF0); tick();
        tick();
        query(TA, TA + POFF, 8'hFF, 8'h07); tick();
        check(ld_s2_match_inv == 1'b1, "R6 mismatch raised", DATA_W'(ld_s2_match_inv), 64'h1);
        check(ld_s2_data_inv && ld_s2_data_inv_idx == 2, "R5 youngest missing index",
              DATA_W'(ld_s2_data_inv_idx), 64'h2);

        // R9: in-order release
        st_release = 1; tick();
        query(TA, TA + POFF, 8'h0C, 8'h01); tick();
        check(ld_s2_fwd_mask == 8'h00, "R9 released entry silent", DATA_W'(ld_s2_fwd_mask), '0);

        // R10: full queue ignores issue
        for (int k = 0; k < 6; k++) begin issue(9, 9 + POFF, 8'h11); tick(); end
        issue(TB, TB + POFF, 8'hFF); tick();
        tick(); tick();
        query(TB, TB + POFF, 8'hFF, 8'hFF); tick();
        check(ld_s2_fwd_mask == 8'h00, "R10 issue while full ignored", DATA_W'(ld_s2_fwd_mask), '0);
        for (int k = 0; k < SQ_ENTRIES; k++) begin st_release = 1; tick(); end

        // random phase
        for (int n = 0; n < 3000; n++) begin
            int cnt;
            cnt = aptr - rptr;
            if ($urandom_range(2) == 0) begin
                int t;
                t = $urandom_range(3);
                issue(t, ($urandom_range(9) == 0) ? t + POFF + 1 : t + POFF,
                      LANES'($urandom_range(255, 1)));
            end
            if (cnt > 0 && $urandom_range(2) == 0) begin
                int e;
                e = (rptr + $urandom_range(cnt - 1)) % SQ_ENTRIES;
                if (mv[e]) data_wr(e, {$urandom, $urandom});
            end
            if (cnt > 0 && mv[rptr % SQ_ENTRIES] && $urandom_range(5) == 0) st_release = 1;
            if ($urandom_range(1) == 0) begin
                int t;
                t = $urandom_range(3);
                query(t, t + POFF, LANES'($urandom_range(255)), SQ_ENTRIES'($urandom_range(255)));
            end
            tick();
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule